// File: doc/BRIEF.md
# UART Multiprocessor Address Filter

This block sits behind a UART receiver in a multi-drop serial network. Each received character arrives as a data byte plus a ninth bit. A ninth bit of 1 marks an address character. The filter decides whether the node should take each character, and it raises a one-cycle accept strobe for the ones it takes. Two 8-bit registers, a node address and a per-bit enable mask, are loaded over a small write port.

An address character matches in one of two ways:

- **Given pattern.** Every bit where the mask is 1 must equal the corresponding node address bit.
- **Broadcast pattern.** Every bit that is 1 in (address OR mask) must be 1 in the received byte.

One node can therefore answer to a family of addresses and to a shared broadcast address. Both registers clear on reset, so every address matches and filtering is effectively off. When the multiprocessor mode input is low, every character is passed, as in a plain UART. Software clears that bit once the node has been addressed, which lets the following data characters through.

Top module: `mp_addr_filter`

## Requirements
- R1: After reset the address and mask registers are zero, so with mode set every address character (ninth bit 1) is accepted and reported as a given match (status 01).
- R2: With mode set and ninth bit 1, a character is a given match when, for each bit whose mask bit is 1, the received bit equals the address bit; bits with mask 0 are ignored.
- R3: With mode set and ninth bit 1, a character is a broadcast match when it has a 1 in every bit position that is 1 in (address OR mask); positions that are 0 there are ignored.
- R4: When a character is both a given and a broadcast match, the status reports given (01); a broadcast-only match reports 10.
- R5: An address character that matches neither pattern raises no accept, and the status reads 00.
- R6: With mode clear, every character is accepted regardless of ninth bit or value, with status 11.
- R7: With mode set, a character whose ninth bit is 0 raises no accept, and the status reads 00.
- R8: Accept and status are registered. They are valid for exactly the one clock after the cycle in which the frame-valid strobe is high, and both read 0 in every other cycle.
- R9: A write with select 0 loads the address register and a write with select 1 loads the mask register. A write in the same cycle as a frame-valid strobe does not affect that frame, only later ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the address register, 1 selects the mask register |
| cfg_wdata | input | 8 | Register write data |
| rx_byte | input | 8 | Received character, low eight bits |
| rx_bit9 | input | 1 | Received ninth bit, 1 marks an address character |
| rx_valid | input | 1 | One-cycle strobe, character present |
| mp_mode | input | 1 | Multiprocessor filtering enable |
| accept | output | 1 | One-cycle strobe, character taken |
| match_kind | output | 2 | 00 none, 01 given, 10 broadcast, 11 passed unfiltered |

## Verification
The bench first checks the reset-cleared registers. A filter that came up with stale or nonzero registers would drop address characters that should pass. It then runs the worked mask examples, where a don't-care bit next to a required-zero bit separates acceptance from rejection. A design that treats an inverted or shifted mask as don't-care would reject a legal address or let an excluded one through. Characters that hit both patterns check the priority between given and broadcast. A swapped priority reports 10 where 01 is required. A register write landing in the same cycle as a frame checks that the compare uses the old register values; a design that bypassed the new value into the compare would accept or reject that frame wrongly. Random writes and frames, with addresses biased to lie one bit away from the node address, cover the rest against a bench model.

// File: rtl/mp_addr_filter_pkg.sv
package mp_addr_filter_pkg;
  typedef enum logic [1:0] {
    MK_NONE  = 2'b00,
    MK_GIVEN = 2'b01,
    MK_BCAST = 2'b10,
    MK_PASS  = 2'b11
  } match_kind_t;

  localparam logic SEL_ADDR = 1'b0;
  localparam logic SEL_MASK = 1'b1;
endpackage

// File: rtl/mpaf_cfg_regs.sv
module mpaf_cfg_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] node_addr,
  output logic [DATA_W-1:0] node_mask
);
  import mp_addr_filter_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      node_addr <= '0;
      node_mask <= '0;
    end else if (wr) begin
      if (sel == SEL_ADDR) node_addr <= wdata;
      else                 node_mask <= wdata;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (node_addr == '0 && node_mask == '0)); // R1
  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (rst)
    $past(wr && sel == SEL_ADDR && !rst) |-> node_addr == $past(wdata)); // R9
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
    $past(wr && sel == SEL_MASK && !rst) |-> node_mask == $past(wdata)); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(!wr && !rst) |-> ($stable(node_addr) && $stable(node_mask))); // R9
endmodule

// File: rtl/mpaf_matcher.sv
module mpaf_matcher #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] rx_byte,
  input  logic [DATA_W-1:0] node_addr,
  input  logic [DATA_W-1:0] node_mask,
  output logic              given_hit,
  output logic              bcast_hit
);
  logic [DATA_W-1:0] given_ok;
  logic [DATA_W-1:0] bcast_ok;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic bc_need_one;
    assign bc_need_one = node_addr[i] | node_mask[i];
    assign given_ok[i] = !node_mask[i] || (rx_byte[i] == node_addr[i]);
    assign bcast_ok[i] = !bc_need_one || rx_byte[i];
  end

  assign given_hit = &given_ok;
  assign bcast_hit = &bcast_ok;
endmodule

// File: rtl/mpaf_accept_ctrl.sv
module mpaf_accept_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_valid,
  input  logic       rx_bit9,
  input  logic       mp_mode,
  input  logic       given_hit,
  input  logic       bcast_hit,
  output logic       accept,
  output logic [1:0] match_kind
);
  import mp_addr_filter_pkg::*;

  match_kind_t kind_nxt;

  always_comb begin
    kind_nxt = MK_NONE;
    if (!mp_mode)       kind_nxt = MK_PASS;
    else if (!rx_bit9)  kind_nxt = MK_NONE;
    else if (given_hit) kind_nxt = MK_GIVEN;
    else if (bcast_hit) kind_nxt = MK_BCAST;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accept     <= 1'b0;
      match_kind <= MK_NONE;
    end else if (rx_valid) begin
      accept     <= (kind_nxt != MK_NONE);
      match_kind <= kind_nxt;
    end else begin
      accept     <= 1'b0;
      match_kind <= MK_NONE;
    end
  end

  AST_STROBE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    accept |-> $past(rx_valid)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$past(rx_valid) |-> (!accept && match_kind == MK_NONE)); // R8
  AST_PASS_MODE: assert property (@(posedge clk) disable iff (rst)
    $past(rx_valid && !mp_mode && !rst) |-> (accept && match_kind == MK_PASS)); // R6
  AST_DATA_DROP: assert property (@(posedge clk) disable iff (rst)
    $past(rx_valid && mp_mode && !rx_bit9 && !rst) |-> (!accept && match_kind == MK_NONE)); // R7
  AST_GIVEN_WINS: assert property (@(posedge clk) disable iff (rst)
    $past(rx_valid && mp_mode && rx_bit9 && given_hit && !rst) |-> match_kind == MK_GIVEN); // R4
  AST_MISS_REJECT: assert property (@(posedge clk) disable iff (rst)
    $past(rx_valid && mp_mode && rx_bit9 && !given_hit && !bcast_hit && !rst)
      |-> (!accept && match_kind == MK_NONE)); // R5
endmodule

// File: rtl/mp_addr_filter.sv
module mp_addr_filter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_bit9,
  input  logic              rx_valid,
  input  logic              mp_mode,
  output logic              accept,
  output logic [1:0]        match_kind
);
  logic [DATA_W-1:0] node_addr;
  logic [DATA_W-1:0] node_mask;
  logic              given_hit;
  logic              bcast_hit;

  mpaf_cfg_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr        (cfg_wr),
    .sel       (cfg_sel),
    .wdata     (cfg_wdata),
    .node_addr (node_addr),
    .node_mask (node_mask)
  );

  mpaf_matcher #(.DATA_W(DATA_W)) u_match (
    .rx_byte   (rx_byte),
    .node_addr (node_addr),
    .node_mask (node_mask),
    .given_hit (given_hit),
    .bcast_hit (bcast_hit)
  );

  mpaf_accept_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .rx_valid   (rx_valid),
    .rx_bit9    (rx_bit9),
    .mp_mode    (mp_mode),
    .given_hit  (given_hit),
    .bcast_hit  (bcast_hit),
    .accept     (accept),
    .match_kind (match_kind)
  );
endmodule

// File: tb/mp_addr_filter_test.sv
module mp_addr_filter_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic       cfg_sel = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] rx_byte = '0;
  logic       rx_bit9 = 1'b0;
  logic       rx_valid = 1'b0;
  logic       mp_mode = 1'b0;
  logic       accept;
  logic [1:0] match_kind;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] m_addr = '0;
  logic [7:0] m_mask = '0;

  always #2.5 clk = ~clk;

  mp_addr_filter #(.DATA_W(8)) uut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rx_byte(rx_byte), .rx_bit9(rx_bit9), .rx_valid(rx_valid), .mp_mode(mp_mode),
    .accept(accept), .match_kind(match_kind)
  );

  function automatic logic [1:0] exp_kind(input logic [7:0] a, input logic [7:0] m,
                                           input logic [7:0] d, input logic b9, input logic md);
    logic [7:0] bc;
    bc = a | m;
    if (!md) return 2'b11;
    if (!b9) return 2'b00;
    if (((d ^ a) & m) == 8'h00) return 2'b01;
    if ((d & bc) == bc) return 2'b10;
    return 2'b00;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got accept/kind %b, expected %b", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic sel, input logic [7:0] v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (sel) m_mask = v; else m_addr = v;
  endtask

  task automatic frame(input logic [7:0] d, input logic b9, input logic md,
                       input bit wr_same, input logic wsel, input logic [7:0] wv,
                       input string tag);
    logic [1:0] ek;
    ek = exp_kind(m_addr, m_mask, d, b9, md);
    @(negedge clk);
    rx_byte = d; rx_bit9 = b9; mp_mode = md; rx_valid = 1'b1;
    if (wr_same) begin
      cfg_wr = 1'b1; cfg_sel = wsel; cfg_wdata = wv;
    end
    @(negedge clk);
    rx_valid = 1'b0; cfg_wr = 1'b0;
    if (wr_same) begin
      if (wsel) m_mask = wv; else m_addr = wv;
    end
    check(accept == (ek != 2'b00) && match_kind == ek, tag,
          {accept, match_kind}, {(ek != 2'b00), ek});
    @(negedge clk);
    check(!accept && match_kind == 2'b00, "R8 strobe width",
          {accept, match_kind}, 3'b000);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!accept && match_kind == 2'b00, "R8 idle after reset", {accept, match_kind}, 3'b000);

    // R1: cleared registers pass every address with given status
    frame(8'h5A, 1'b1, 1'b1, 0, 0, 8'h00, "R1 reset accepts 5A");
    frame(8'hFF, 1'b1, 1'b1, 0, 0, 8'h00, "R1 reset accepts FF");
    frame(8'h00, 1'b1, 1'b1, 0, 0, 8'h00, "R1 reset accepts 00");

    // R2/R5 worked example one
    write_reg(1'b0, 8'hC0);
    write_reg(1'b1, 8'hFD);
    frame(8'hC0, 1'b1, 1'b1, 0, 0, 8'h00, "R2 C0 given");
    frame(8'hC2, 1'b1, 1'b1, 0, 0, 8'h00, "R2 C2 dont-care bit");
    frame(8'hC1, 1'b1, 1'b1, 0, 0, 8'h00, "R5 C1 rejected");
    // R3 broadcast only
    frame(8'hFF, 1'b1, 1'b1, 0, 0, 8'h00, "R3 FF broadcast");
    frame(8'hFD, 1'b1, 1'b1, 0, 0, 8'h00, "R3 FD broadcast");

    // R2/R5 worked example two
    write_reg(1'b0, 8'hE0);
    write_reg(1'b1, 8'hFC);
    frame(8'hE3, 1'b1, 1'b1, 0, 0, 8'h00, "R2 E3 given");
    frame(8'hE4, 1'b1, 1'b1, 0, 0, 8'h00, "R5 E4 rejected");

    // R4: both patterns hit, given wins
    write_reg(1'b0, 8'hFF);
    write_reg(1'b1, 8'h0F);
    frame(8'hFF, 1'b1, 1'b1, 0, 0, 8'h00, "R4 given over broadcast");

    // R6 / R7
    frame(8'h12, 1'b0, 1'b0, 0, 0, 8'h00, "R6 mode off data");
    frame(8'h34, 1'b1, 1'b0, 0, 0, 8'h00, "R6 mode off address");
    frame(8'hFF, 1'b0, 1'b1, 0, 0, 8'h00, "R7 data frame dropped");

    // R9: same-cycle write applies to later frames only
    write_reg(1'b0, 8'hC0);
    write_reg(1'b1, 8'hFF);
    frame(8'hC0, 1'b1, 1'b1, 1, 1'b0, 8'h30, "R9 same-cycle addr write ignored");
    frame(8'hC0, 1'b1, 1'b1, 0, 0, 8'h00, "R9 new addr rejects old");
    frame(8'h30, 1'b1, 1'b1, 1, 1'b1, 8'h00, "R9 same-cycle mask write ignored");
    frame(8'h77, 1'b1, 1'b1, 0, 0, 8'h00, "R9 zero mask now given");

    // random mix (R2 R3 R4 R5 R6 R7 R9)
    for (int i = 0; i < 400; i++) begin
      int unsigned r;
      logic [7:0] d;
      r = $urandom % 10;
      if (r < 2) begin
        write_reg(1'($urandom % 2), 8'($urandom));
      end else begin
        if ($urandom % 2) d = m_addr ^ (8'h01 << ($urandom % 8));
        else if ($urandom % 3 == 0) d = m_addr | m_mask;
        else d = 8'($urandom);
        frame(d, 1'($urandom % 4 != 0), 1'($urandom % 4 != 0),
              ($urandom % 8 == 0), 1'($urandom % 2), 8'($urandom), "R2 random frame");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule